// File: doc/BRIEF.md
# Programmable Pulse Generator Core

This block makes timed digital pulses for test and stimulus logic. Each generation cycle begins with a one-cycle pulse on `trig_out`. After a programmable delay, a pulse of programmable width appears on `pos_out`. Its complement appears on `neg_out` during the same cycles. A double mode adds a second pulse of the same width, a programmable spacing after the first pulse starts. All times are whole clock cycles. Delay, width, spacing and period are counted relative to the cycle in which `trig_out` is high, which is cycle 0.

A cycle can start from one of four sources. The internal rate generator repeats on its own at the programmed period. An external trigger is asynchronous and acts on its rising edge. A manual strobe is synchronous. In gated operation the internal rate generator runs only while the gate input is high. Any request that arrives while a cycle is still active is dropped. Delay, width, spacing and the double flag are captured when a cycle starts, so changing them mid-cycle only affects the next cycle.

Top module: `pulse_gen_core`

## Requirements
- R1: During and right after reset, `trig_out` and `pos_out` are 0 and `neg_out` is 1.
- R2: With source code 0 (internal), `trig_out` is a one-cycle pulse that repeats every `cfg_period` cycles (a value of 0 acts as 1), provided the period is longer than the cycle's pulse span. The first pulse is high in the cycle `cfg_period` clocks after the source is selected.
- R3: Taking the `trig_out` cycle as cycle 0, `pos_out` is high in cycles `cfg_delay` through `cfg_delay + W - 1`. Here W is `cfg_width`, except that a width of 0 acts as 1.
- R4: `neg_out` is always the inverse of `pos_out`, and both change on the same clock edge.
- R5: With `cfg_double` = 1, a second pulse of width W starts at cycle `cfg_delay + S`. S is `cfg_spacing`, raised to W + 1 when it is smaller than that.
- R6: With source code 1 (external), a rising edge on `ext_trig` passes through a two-flop synchroniser. `trig_out` is then high in the third clock cycle after the input rises. A level held high starts only one cycle.
- R7: A trigger request that arrives while a cycle is active (from `trig_out` until its last pulse cycle) is dropped. It is not remembered.
- R8: With source code 2 (manual), each cycle in which `manual_strobe` is high while the block is idle starts a cycle, with `trig_out` high in the next clock cycle. Sources that are not selected have no effect.
- R9: With source code 3 (gated), the internal rate generator runs only while the synchronised gate is high. Its first trigger comes `cfg_period` cycles after the gate becomes visible. Once the gate falls, a cycle already in progress completes and no further trigger follows.
- R10: Changing delay, width, spacing or the double flag during an active cycle leaves that cycle's pulses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2 | Trigger source: 0 internal, 1 external, 2 manual, 3 gated |
| cfg_double | input | 1 | 1 selects two pulses per cycle |
| cfg_period | input | CNT_W | Internal repetition period in cycles |
| cfg_delay | input | CNT_W | Cycles from the trigger-out cycle to the first pulse |
| cfg_width | input | CNT_W | Pulse width in cycles (0 acts as 1) |
| cfg_spacing | input | CNT_W | Start-to-start spacing of the two pulses in double mode |
| ext_trig | input | 1 | Asynchronous external trigger, rising edge active |
| manual_strobe | input | 1 | Synchronous single-shot request |
| gate_in | input | 1 | Asynchronous gate for gated operation |
| trig_out | output | 1 | One-cycle marker at the start of each cycle |
| pos_out | output | 1 | Positive pulse output |
| neg_out | output | 1 | Complementary pulse output |

## Verification
The assertions take three things for granted about the inputs:
- `manual_strobe` is synchronous to `clk`.
- `ext_trig` and `gate_in` may change at any time, because they are synchronised inside the block.
- The configuration inputs may change at any time.

The bench keeps to these by driving every input on the falling clock edge and by giving the strobe a single-cycle pulse. For the internal and gated tests it also keeps the period longer than the pulse span, so that each trigger position follows from the period alone. Requests are deliberately issued while a cycle is still active, to exercise the drop rule.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'd0,
        SRC_EXTERNAL = 2'd1,
        SRC_MANUAL   = 2'd2,
        SRC_GATED    = 2'd3
    } pgc_src_e;

endpackage

// File: rtl/pgc_sync.sv
module pgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);

    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R6

endmodule

// File: rtl/pgc_rate.sv
module pgc_rate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic             fire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] term;
    } rate_s;

    rate_s            r_d, r_q;
    logic [CNT_W-1:0] term_in;

    always_comb begin
        term_in = (period == '0) ? '0 : period - CNT_W'(1);
        fire    = en && (r_q.cnt == r_q.term);
        r_d     = r_q;
        if (!en) begin
            r_d.cnt  = '0;
            r_d.term = term_in;
        end else if (fire) begin
            r_d.cnt  = '0;
            r_d.term = term_in;
        end else begin
            r_d.cnt  = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (r_q.cnt <= r_q.term)); // R2

    AST_RATE_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (r_q.cnt == '0)); // R9

endmodule

// File: rtl/pgc_seq.sv
module pgc_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_spacing,
    input  logic             cfg_double,
    output logic             trig,
    output logic             pos,
    output logic             neg
);

    localparam int EW = CNT_W + 2;

    typedef struct packed {
        logic          busy;
        logic [EW-1:0] t;
        logic [EW-1:0] dly;
        logic [EW-1:0] wid;
        logic [EW-1:0] sp;
        logic [EW-1:0] last;
        logic          dbl;
        logic          trig;
        logic          pos;
        logic          neg;
    } seq_s;

    seq_s          s_d, s_q;
    logic [EW-1:0] dly_in, wid_in, wid_eff, sp_in, sp_eff, span;

    function automatic logic in_window(input logic [EW-1:0] t, input logic [EW-1:0] dly,
                                       input logic [EW-1:0] wid, input logic [EW-1:0] sp,
                                       input logic dbl);
        logic [EW-1:0] second;
        logic          first_hit, second_hit;
        second     = dly + sp;
        first_hit  = (t >= dly) && (t < dly + wid);
        second_hit = dbl && (t >= second) && (t < second + wid);
        return first_hit || second_hit;
    endfunction

    always_comb begin
        dly_in  = EW'(cfg_delay);
        wid_in  = EW'(cfg_width);
        wid_eff = (wid_in == '0) ? EW'(1) : wid_in;
        sp_in   = EW'(cfg_spacing);
        sp_eff  = (sp_in < wid_eff + EW'(1)) ? wid_eff + EW'(1) : sp_in;
        span    = dly_in + wid_eff + (cfg_double ? sp_eff : '0);

        s_d      = s_q;
        s_d.trig = 1'b0;
        if (s_q.busy) begin
            if (s_q.t == s_q.last) s_d.busy = 1'b0;
            else                   s_d.t    = s_q.t + EW'(1);
        end else if (start_req) begin
            s_d.busy = 1'b1;
            s_d.t    = '0;
            s_d.dly  = dly_in;
            s_d.wid  = wid_eff;
            s_d.sp   = sp_eff;
            s_d.dbl  = cfg_double;
            s_d.last = span - EW'(1);
            s_d.trig = 1'b1;
        end
        s_d.pos = s_d.busy && in_window(s_d.t, s_d.dly, s_d.wid, s_d.sp, s_d.dbl);
        s_d.neg = ~s_d.pos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.neg <= 1'b1;
        end else begin
            s_q     <= s_d;
        end
    end

    assign trig = s_q.trig;
    assign pos  = s_q.pos;
    assign neg  = s_q.neg;

    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |=> !s_q.trig); // R2

    AST_TRIG_OPENS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |-> (s_q.busy && s_q.t == '0)); // R7

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.t != s_q.last) |=> !s_q.trig); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> !s_q.pos); // R3

    AST_NEG_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.neg == !s_q.pos); // R4

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.t != s_q.last) |=> ($stable(s_q.dly) && $stable(s_q.wid))); // R10

endmodule

// File: rtl/pulse_gen_core.sv
module pulse_gen_core #(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_src,
    input  logic             cfg_double,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic [CNT_W-1:0] cfg_spacing,
    input  logic             ext_trig,
    input  logic             manual_strobe,
    input  logic             gate_in,
    output logic             trig_out,
    output logic             pos_out,
    output logic             neg_out
);

    import pgc_pkg::*;

    localparam int N_ASYNC = 2;
    localparam int IDX_EXT = 0;
    localparam int IDX_GATE = 1;

    logic [N_ASYNC-1:0] async_in, sync_lvl, sync_rise;
    pgc_src_e           src;
    logic               rate_en, rate_fire, start_req;

    assign async_in = {gate_in, ext_trig};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        pgc_sync #(.STAGES(SYNC_STGS)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (async_in[g]),
            .level (sync_lvl[g]),
            .rise  (sync_rise[g])
        );
    end

    always_comb begin
        src     = pgc_src_e'(cfg_src);
        rate_en = (src == SRC_INTERNAL) || ((src == SRC_GATED) && sync_lvl[IDX_GATE]);
        case (src)
            SRC_INTERNAL: start_req = rate_fire;
            SRC_EXTERNAL: start_req = sync_rise[IDX_EXT];
            SRC_MANUAL:   start_req = manual_strobe;
            default:      start_req = rate_fire;
        endcase
    end

    pgc_rate #(.CNT_W(CNT_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rate_en),
        .period (cfg_period),
        .fire   (rate_fire)
    );

    pgc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .cfg_delay   (cfg_delay),
        .cfg_width   (cfg_width),
        .cfg_spacing (cfg_spacing),
        .cfg_double  (cfg_double),
        .trig        (trig_out),
        .pos         (pos_out),
        .neg         (neg_out)
    );

    AST_GATE_LOW_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == SRC_GATED) && !sync_lvl[IDX_GATE]) |-> !start_req); // R9

endmodule

// File: tb/pulse_gen_core_bench.sv
module pulse_gen_core_bench;

    localparam int CW = 16;
    localparam int TL = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_src = 2'd2;
    logic          cfg_double = 1'b0;
    logic [CW-1:0] cfg_period = '0, cfg_delay = '0, cfg_width = '0, cfg_spacing = '0;
    logic          ext_trig = 1'b0, manual_strobe = 1'b0, gate_in = 1'b0;
    logic          trig_out, pos_out, neg_out;

    int n_chk = 0;
    int n_fail = 0;
    bit tr_t [0:TL-1];
    bit tr_p [0:TL-1];
    bit tr_n [0:TL-1];
    bit ex_t [0:TL-1];
    bit ex_p [0:TL-1];

    always #4 clk = ~clk;

    pulse_gen_core u_pulse_gen_core (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_double(cfg_double),
        .cfg_period(cfg_period), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
        .cfg_spacing(cfg_spacing), .ext_trig(ext_trig), .manual_strobe(manual_strobe),
        .gate_in(gate_in), .trig_out(trig_out), .pos_out(pos_out), .neg_out(neg_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit win(int t, int d, int w, bit dbl, int s);
        int we, se;
        we = (w == 0) ? 1 : w;
        se = (s < we + 1) ? we + 1 : s;
        return (t >= d && t < d + we) || (dbl && t >= d + se && t < d + se + we);
    endfunction

    task automatic clear_exp();
        for (int i = 0; i < TL; i++) begin ex_t[i] = 1'b0; ex_p[i] = 1'b0; end
    endtask

    task automatic add_cycle(int t0, int d, int w, bit dbl, int s);
        ex_t[t0] = 1'b1;
        for (int k = 0; k < 64; k++)
            if (t0 + k < TL && win(k, d, w, dbl, s)) ex_p[t0 + k] = 1'b1;
    endtask

    task automatic sample(int i);
        tr_t[i] = trig_out; tr_p[i] = pos_out; tr_n[i] = neg_out;
    endtask

    task automatic compare(int n, string req);
        int bt, bp, bn;
        bt = -1; bp = -1; bn = -1;
        for (int i = 0; i < n; i++) begin
            if (bt < 0 && tr_t[i] != ex_t[i]) bt = i;
            if (bp < 0 && tr_p[i] != ex_p[i]) bp = i;
            if (bn < 0 && tr_n[i] == tr_p[i]) bn = i;
        end
        check(bt < 0, req, $sformatf("trig_out at cycle %0d", bt),
              (bt < 0) ? 0 : int'(tr_t[bt]), (bt < 0) ? 0 : int'(ex_t[bt]));
        check(bp < 0, req, $sformatf("pos_out at cycle %0d", bp),
              (bp < 0) ? 0 : int'(tr_p[bp]), (bp < 0) ? 0 : int'(ex_p[bp]));
        check(bn < 0, "R4", $sformatf("neg_out at cycle %0d", bn),
              (bn < 0) ? 0 : int'(tr_n[bn]), (bn < 0) ? 0 : int'(!tr_p[bn]));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic man_shot(int n);
        manual_strobe = 1'b1;
        @(negedge clk);
        manual_strobe = 1'b0;
        sample(0);
        for (int i = 1; i < n; i++) begin @(negedge clk); sample(i); end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        idle(3);
        check(trig_out == 1'b0 && pos_out == 1'b0 && neg_out == 1'b1, "R1",
              "outputs in reset {trig,pos,neg}", {trig_out, pos_out, neg_out}, 3'b001);
        rst_n = 1'b1;
        idle(2);
        check(trig_out == 1'b0 && pos_out == 1'b0 && neg_out == 1'b1, "R1",
              "outputs after reset {trig,pos,neg}", {trig_out, pos_out, neg_out}, 3'b001);

        // R3 / R5: manual shots over delay, width, spacing, double
        cfg_src = 2'd2;
        for (int d = 0; d < 4; d++)
            for (int w = 0; w < 4; w++)
                for (int dbl = 0; dbl < 2; dbl++)
                    for (int s = 0; s < 6; s++) begin
                        if (dbl == 0 && s > 0) continue;
                        cfg_delay = CW'(d); cfg_width = CW'(w);
                        cfg_double = dbl[0]; cfg_spacing = CW'(s);
                        clear_exp(); add_cycle(0, d, w, dbl[0], s);
                        man_shot(24);
                        compare(24, (dbl != 0) ? "R5" : "R3");
                    end

        // R8: external edge and gate ignored in manual mode
        cfg_delay = 1; cfg_width = 2; cfg_double = 0;
        clear_exp();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); sample(i);
            if (i == 1) begin ext_trig = 1'b1; gate_in = 1'b1; end
        end
        compare(16, "R8");
        ext_trig = 1'b0; gate_in = 1'b0;
        idle(6);

        // R10: reconfigure during an active cycle
        cfg_delay = 2; cfg_width = 4; cfg_double = 0; cfg_spacing = 0;
        clear_exp(); add_cycle(0, 2, 4, 1'b0, 0);
        manual_strobe = 1'b1;
        @(negedge clk);
        manual_strobe = 1'b0;
        sample(0);
        cfg_delay = 0; cfg_width = 1; cfg_double = 1; cfg_spacing = 2;
        for (int i = 1; i < 16; i++) begin @(negedge clk); sample(i); end
        compare(16, "R10");
        clear_exp(); add_cycle(0, 0, 1, 1'b1, 2);
        man_shot(12);
        compare(12, "R10");

        // R2: internal rate over several periods
        cfg_delay = 1; cfg_width = 2; cfg_double = 0;
        for (int p = 6; p < 10; p++) begin
            cfg_src = 2'd2; cfg_period = CW'(p);
            idle(12);
            clear_exp();
            for (int k = p - 1; k < 60; k += p) add_cycle(k, 1, 2, 1'b0, 0);
            cfg_src = 2'd0;
            for (int i = 0; i < 60; i++) begin @(negedge clk); sample(i); end
            compare(60, "R2");
        end
        cfg_src = 2'd2;
        idle(12);

        // R6 / R7 / R8: external trigger, dropped edge, ignored strobe
        cfg_delay = 1; cfg_width = 6; cfg_double = 0;
        cfg_src = 2'd1;
        idle(4);
        clear_exp(); add_cycle(2, 1, 6, 1'b0, 0); add_cycle(25, 1, 6, 1'b0, 0);
        ext_trig = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); sample(i);
            if (i == 3)  ext_trig = 1'b0;
            if (i == 4)  ext_trig = 1'b1;
            if (i == 20) ext_trig = 1'b0;
            if (i == 22) ext_trig = 1'b1;
            if (i == 35) manual_strobe = 1'b1;
            if (i == 36) manual_strobe = 1'b0;
        end
        compare(26, "R6");
        check(tr_t[6] == 1'b0 && tr_t[7] == 1'b0 && tr_t[8] == 1'b0 && tr_t[9] == 1'b0, "R7",
              "trigger from edge during active cycle", int'(tr_t[8]) + int'(tr_t[9]), 0);
        compare(40, "R8");
        ext_trig = 1'b0;
        idle(6);

        // R9: gated rate generator
        cfg_period = 8; cfg_delay = 1; cfg_width = 2; cfg_double = 0;
        cfg_src = 2'd3;
        clear_exp(); add_cycle(19, 1, 2, 1'b0, 0); add_cycle(27, 1, 2, 1'b0, 0);
        for (int i = 0; i < 70; i++) begin
            @(negedge clk); sample(i);
            if (i == 9)  gate_in = 1'b1;
            if (i == 27) gate_in = 1'b0;
        end
        compare(70, "R9");

        finish_run();
    end

endmodule